// File: doc/BRIEF.md
# Banked General-Purpose Register File with Exchanges

This block is the general-purpose register store of an 8-bit processor core. It holds four 16-bit register pairs (BC, DE, HL and the accumulator/flags pair), a second copy of each, and a stack pointer that has no second copy. Two access ports serve the rest of the core. The address-side port reads and writes whole 16-bit pairs. The data-side port reads and writes single bytes or whole pairs, and it also accepts a 3-bit register field taken straight from an opcode.

The exchange operations never move data. One operation swaps the roles of DE and HL. A second switches between the two accumulator/flags pairs. A third switches the whole BC/DE/HL bank. Each exchange flips a small pointer bit, so any exchange completes on a single clock edge and the storage needs no extra write ports. The pointer that records the DE/HL swap is kept separately for each BC/DE/HL bank.

Top module: `gpr_bank_file`

## Requirements
- R1: The address port returns the full 16-bit value of the pair named by `a_sel` (00 BC, 01 DE, 10 HL, 11 accumulator/flags) without a clock edge. When `a_use_sp` is 1, the code 11 returns the stack pointer instead. For the other codes `a_use_sp` has no effect.
- R2: When `a_we` is 1, the register that `a_sel`/`a_use_sp` name takes all 16 bits of `a_wdata` on the rising clock edge.
- R3: With `d_fld_en` at 0, the data port uses `d_sel` for the pair and `d_be` for the bytes: bit 1 is the high byte and bit 0 the low byte. 10 is the high byte, 01 the low byte and 11 both. A write with `d_we` changes only the enabled bytes, taking each byte from the same position in `d_wdata`. A read returns the enabled bytes in place and zero in the other byte. The data port never reaches the stack pointer.
- R4: With `d_fld_en` at 1, `d_fld[2:1]` names the pair and `d_fld[0]` names the byte: 0 is the high byte and 1 the low byte. `d_sel` and `d_be` are then ignored.
- R5: The accumulator/flags pair holds the flags in its high byte and the accumulator in its low byte. In field mode the field 110 (flags) always reads as 0x0000. A write through field 110 still updates the flags byte, and that byte shows up in pair reads.
- R6: A pulse on `x_dehl` swaps which storage the codes 01 and 10 reach in the active BC/DE/HL bank, starting with the next edge.
- R7: A pulse on `x_af` switches the code 11 (without `a_use_sp`) to the other accumulator/flags pair.
- R8: A pulse on `x_exx` switches the BC/DE/HL codes to the other bank. Each bank keeps its own DE/HL swap state. When `x_dehl` and `x_exx` pulse together, the DE/HL swap applies to the bank that was active before the edge.
- R9: No exchange changes the stack pointer.
- R10: Writes in a cycle use the mapping in force before that cycle's edge, even when an exchange pulses at the same time. When both ports write the same byte in one cycle, the data port's value is stored.
- R11: Reset clears all four pointer bits, so every code reaches its first-bank storage with no DE/HL swap. Register contents are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the bank pointers |
| a_sel | input | 2 | Address port pair code |
| a_use_sp | input | 1 | Redirects pair code 11 to the stack pointer |
| a_we | input | 1 | Address port write enable |
| a_wdata | input | 2*DW | Address port write data |
| a_rdata | output | 2*DW | Address port read data |
| d_sel | input | 2 | Data port pair code (pair mode) |
| d_be | input | 2 | Data port byte enables (pair mode) |
| d_fld_en | input | 1 | Selects opcode register-field mode |
| d_fld | input | 3 | Opcode register field |
| d_we | input | 1 | Data port write enable |
| d_wdata | input | 2*DW | Data port write data, bytes in place |
| d_rdata | output | 2*DW | Data port read data, bytes in place |
| x_dehl | input | 1 | Swap DE and HL in the active bank |
| x_af | input | 1 | Toggle accumulator/flags pair |
| x_exx | input | 1 | Toggle BC/DE/HL bank |

## Verification
The assertions assume the three exchange inputs are one-cycle decisions sampled at the clock edge. They also assume that reset is held across at least one rising edge, and that nothing else changes the pointer state. The properties that relate the data port read to its selection hold only for reads, so they are qualified with `d_we` low. The bench changes its inputs only on falling edges. It keeps every exchange pulse and write at zero during reset. It fills all nine storage locations before it makes any comparison, so no read ever returns an uninitialised value.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int NBANK  = 2;
    localparam int NSLOT  = 4;
    localparam int NENT   = NBANK * NSLOT;
    localparam int IDXW   = $clog2(NENT);
    localparam int SLOTW  = $clog2(NSLOT);

    typedef enum logic [1:0] {
        PR_BC = 2'd0,
        PR_DE = 2'd1,
        PR_HL = 2'd2,
        PR_AF = 2'd3
    } pair_code_e;

    localparam logic [1:0] BE_HI   = 2'b10;
    localparam logic [1:0] BE_LO   = 2'b01;
    localparam logic [2:0] FLD_FLG = 3'b110;

    typedef struct packed {
        logic       af_alt;
        logic       gp_alt;
        logic [1:0] dehl_x;
    } bank_ptr_t;

endpackage

// File: rtl/gpr_bank_ptr.sv
module gpr_bank_ptr
    import gpr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      x_dehl,
    input  logic      x_af,
    input  logic      x_exx,
    output bank_ptr_t ptr_q
);

    bank_ptr_t ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        // The DE/HL swap belongs to the bank active before this edge
        ptr_d.dehl_x[ptr_q.gp_alt] = ptr_q.dehl_x[ptr_q.gp_alt] ^ x_dehl;
        ptr_d.gp_alt = ptr_q.gp_alt ^ x_exx;
        ptr_d.af_alt = ptr_q.af_alt ^ x_af;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

endmodule

// File: rtl/gpr_port_map.sv
module gpr_port_map
    import gpr_pkg::*;
(
    input  logic [1:0]      code,
    input  logic            use_sp,
    input  bank_ptr_t       ptr,
    output logic [IDXW-1:0] idx,
    output logic            is_sp
);

    logic [SLOTW-1:0] slot;
    logic             bank;
    logic             swp;

    always_comb begin
        swp   = ptr.dehl_x[ptr.gp_alt];
        bank  = ptr.gp_alt;
        slot  = SLOTW'(PR_BC);
        is_sp = 1'b0;
        unique case (pair_code_e'(code))
            PR_BC: slot = SLOTW'(PR_BC);
            PR_DE: slot = swp ? SLOTW'(PR_HL) : SLOTW'(PR_DE);
            PR_HL: slot = swp ? SLOTW'(PR_DE) : SLOTW'(PR_HL);
            PR_AF: begin
                slot  = SLOTW'(PR_AF);
                bank  = ptr.af_alt;
                is_sp = use_sp;
            end
            default: slot = SLOTW'(PR_BC);
        endcase
        idx = {bank, slot};
    end

endmodule

// File: rtl/gpr_store.sv
module gpr_store
    import gpr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            wa_en,
    input  logic            wa_sp,
    input  logic [IDXW-1:0] wa_idx,
    input  logic [2*DW-1:0] wa_data,
    input  logic [1:0]      wd_be,
    input  logic [IDXW-1:0] wd_idx,
    input  logic [2*DW-1:0] wd_data,
    input  logic            ra_sp,
    input  logic [IDXW-1:0] ra_idx,
    output logic [2*DW-1:0] ra_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [2*DW-1:0] rd_data
);

    localparam int PW = 2 * DW;

    typedef struct packed {
        logic [NENT-1:0][PW-1:0] ent;
        logic [PW-1:0]           sp;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wa_en) begin
            if (wa_sp) begin
                st_d.sp = wa_data;
            end else begin
                st_d.ent[wa_idx] = wa_data;
            end
        end
        // Data port applied last so it wins on a shared byte
        for (int b = 0; b < 2; b++) begin
            if (wd_be[b]) begin
                st_d.ent[wd_idx][b*DW +: DW] = wd_data[b*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ra_data = ra_sp ? st_q.sp : st_q.ent[ra_idx];
    assign rd_data = st_q.ent[rd_idx];

endmodule

// File: rtl/gpr_bank_file.sv
module gpr_bank_file
    import gpr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      a_sel,
    input  logic            a_use_sp,
    input  logic            a_we,
    input  logic [2*DW-1:0] a_wdata,
    output logic [2*DW-1:0] a_rdata,
    input  logic [1:0]      d_sel,
    input  logic [1:0]      d_be,
    input  logic            d_fld_en,
    input  logic [2:0]      d_fld,
    input  logic            d_we,
    input  logic [2*DW-1:0] d_wdata,
    output logic [2*DW-1:0] d_rdata,
    input  logic            x_dehl,
    input  logic            x_af,
    input  logic            x_exx
);

    bank_ptr_t       ptr_q;
    logic [IDXW-1:0] a_idx;
    logic            a_is_sp;
    logic [IDXW-1:0] d_idx;
    logic            d_is_sp;
    logic [1:0]      d_code;
    logic [1:0]      d_lane;
    logic            d_zero;
    logic [2*DW-1:0] d_raw;

    gpr_bank_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .x_dehl (x_dehl),
        .x_af   (x_af),
        .x_exx  (x_exx),
        .ptr_q  (ptr_q)
    );

    gpr_port_map u_amap (
        .code   (a_sel),
        .use_sp (a_use_sp),
        .ptr    (ptr_q),
        .idx    (a_idx),
        .is_sp  (a_is_sp)
    );

    // Field-mode decode: pair from upper bits, byte from the odd/even bit
    always_comb begin
        if (d_fld_en) begin
            d_code = d_fld[2:1];
            d_lane = d_fld[0] ? BE_LO : BE_HI;
            d_zero = (d_fld == FLD_FLG);
        end else begin
            d_code = d_sel;
            d_lane = d_be;
            d_zero = 1'b0;
        end
    end

    gpr_port_map u_dmap (
        .code   (d_code),
        .use_sp (1'b0),
        .ptr    (ptr_q),
        .idx    (d_idx),
        .is_sp  (d_is_sp)
    );

    gpr_store #(.DW(DW)) u_store (
        .clk     (clk),
        .wa_en   (a_we),
        .wa_sp   (a_is_sp),
        .wa_idx  (a_idx),
        .wa_data (a_wdata),
        .wd_be   (d_we && !d_is_sp ? d_lane : 2'b00),
        .wd_idx  (d_idx),
        .wd_data (d_wdata),
        .ra_sp   (a_is_sp),
        .ra_idx  (a_idx),
        .ra_data (a_rdata),
        .rd_idx  (d_idx),
        .rd_data (d_raw)
    );

    for (genvar b = 0; b < 2; b++) begin : g_lane
        assign d_rdata[b*DW +: DW] = (d_lane[b] && !d_zero) ? d_raw[b*DW +: DW] : '0;
    end

endmodule

// File: rtl/gpr_bank_file_chk.sv
module gpr_bank_file_chk
    import gpr_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      a_sel,
    input logic            a_use_sp,
    input logic            a_we,
    input logic [2*DW-1:0] a_rdata,
    input logic [1:0]      d_be,
    input logic            d_fld_en,
    input logic [2:0]      d_fld,
    input logic            d_we,
    input logic [2*DW-1:0] d_rdata,
    input logic            x_dehl,
    input logic            x_af,
    input logic            x_exx,
    input bank_ptr_t       ptr_q
);

    // R3
    low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_fld_en && !d_we && d_be == BE_LO) |-> d_rdata[2*DW-1:DW] == '0);

    // R5
    flag_field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_fld_en && !d_we && d_fld == FLD_FLG) |-> d_rdata == '0);

    // R6
    dehl_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_dehl && !ptr_q.gp_alt) |=> ptr_q.dehl_x[0] != $past(ptr_q.dehl_x[0]));

    // R6
    dehl_bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_dehl && ptr_q.gp_alt) |=> ptr_q.dehl_x[1] != $past(ptr_q.dehl_x[1]));

    // R7
    af_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_af |=> ptr_q.af_alt != $past(ptr_q.af_alt));

    // R8
    exx_keeps_swaps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_exx && !x_dehl) |=> (ptr_q.gp_alt != $past(ptr_q.gp_alt)) && $stable(ptr_q.dehl_x));

    // R9
    sp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_use_sp && a_sel == 2'b11 && !a_we) |=>
            (!(a_use_sp && a_sel == 2'b11) || a_rdata == $past(a_rdata)));

    // R11
    reset_ptr_chk: assert property (@(posedge clk)
        !rst_n |=> ptr_q == '0);

endmodule

bind gpr_bank_file gpr_bank_file_chk #(.DW(DW)) u_chk (.*);

// File: tb/gpr_bank_file_bench.sv
`timescale 1ns/1ps
module gpr_bank_file_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  a_sel = '0;
    logic        a_use_sp = 1'b0;
    logic        a_we = 1'b0;
    logic [15:0] a_wdata = '0;
    logic [15:0] a_rdata;
    logic [1:0]  d_sel = '0;
    logic [1:0]  d_be = '0;
    logic        d_fld_en = 1'b0;
    logic [2:0]  d_fld = '0;
    logic        d_we = 1'b0;
    logic [15:0] d_wdata = '0;
    logic [15:0] d_rdata;
    logic        x_dehl = 1'b0;
    logic        x_af = 1'b0;
    logic        x_exx = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    bit done = 0;
    string ctx = "INIT";

    // Reference: logical values moved on every exchange
    logic [15:0] cur [4];
    logic [15:0] shd [4];
    logic [15:0] sp_m;
    int gpb = 0, afb = 0, sw0 = 0, sw1 = 0;

    always #2.5 clk = ~clk;

    gpr_bank_file u_gpr_bank_file (.*);

    task automatic swap_cur_dehl();
        logic [15:0] t = cur[1]; cur[1] = cur[2]; cur[2] = t;
    endtask

    task automatic exp_data(output logic [15:0] e, output logic [1:0] lane, output int code);
        if (d_fld_en) begin
            code = int'(d_fld[2:1]);
            lane = d_fld[0] ? 2'b01 : 2'b10;
        end else begin
            code = int'(d_sel);
            lane = d_be;
        end
        e = cur[code] & {{8{lane[1]}}, {8{lane[0]}}};
        if (d_fld_en && d_fld == 3'b110) e = '0;
    endtask

    task automatic compare();
        logic [15:0] ea, ed;
        logic [1:0]  ln;
        int          cd;
        string       ta, td;
        ea = (a_use_sp && a_sel == 2'b11) ? sp_m : cur[a_sel];
        ta = (a_use_sp && a_sel == 2'b11) ? "R9" : "R1";
        exp_data(ed, ln, cd);
        td = !d_fld_en ? "R3" : (d_fld == 3'b110 ? "R5" : "R4");
        n_cmp += 2;
        if (a_rdata !== ea) begin
            n_bad++;
            $display("FAIL %s [%s] a_rdata got %h expected %h", ta, ctx, a_rdata, ea);
        end
        if (d_rdata !== ed) begin
            n_bad++;
            $display("FAIL %s [%s] d_rdata got %h expected %h", td, ctx, d_rdata, ed);
        end
    endtask

    task automatic model_edge();
        logic [15:0] ed, t;
        logic [1:0]  ln;
        int          cd;
        if (!rst_n) return;
        if (a_we) begin
            if (a_use_sp && a_sel == 2'b11) sp_m = a_wdata;
            else cur[a_sel] = a_wdata;
        end
        exp_data(ed, ln, cd);
        if (d_we) begin
            if (ln[1]) cur[cd][15:8] = d_wdata[15:8];
            if (ln[0]) cur[cd][7:0]  = d_wdata[7:0];
        end
        if (x_dehl) begin
            swap_cur_dehl();
            if (gpb == 0) sw0 ^= 1; else sw1 ^= 1;
        end
        if (x_exx) begin
            for (int i = 0; i < 3; i++) begin
                t = cur[i]; cur[i] = shd[i]; shd[i] = t;
            end
            gpb ^= 1;
        end
        if (x_af) begin
            t = cur[3]; cur[3] = shd[3]; shd[3] = t;
            afb ^= 1;
        end
    endtask

    // R11: return the view to the first-bank layout without a DE/HL swap
    task automatic model_reset();
        logic [15:0] t;
        if ((gpb == 0 ? sw0 : sw1) != 0) swap_cur_dehl();
        if ((gpb == 0 ? sw1 : sw0) != 0) begin
            t = shd[1]; shd[1] = shd[2]; shd[2] = t;
        end
        if (gpb != 0) begin
            for (int i = 0; i < 3; i++) begin
                t = cur[i]; cur[i] = shd[i]; shd[i] = t;
            end
        end
        if (afb != 0) begin
            t = cur[3]; cur[3] = shd[3]; shd[3] = t;
        end
        gpb = 0; afb = 0; sw0 = 0; sw1 = 0;
    endtask

    task automatic idle();
        a_we = 0; d_we = 0; x_dehl = 0; x_af = 0; x_exx = 0;
        a_use_sp = 0; d_fld_en = 0;
    endtask

    task automatic step();
        #1;
        if (cmp_on) compare();
        model_edge();
        @(negedge clk);
    endtask

    task automatic awrite(input logic [1:0] s, input bit usp, input logic [15:0] v);
        idle(); a_sel = s; a_use_sp = usp; a_we = 1; a_wdata = v; step();
    endtask

    task automatic sweep_reads();
        idle();
        for (int s = 0; s < 5; s++) begin
            a_sel = s[1:0]; a_use_sp = (s == 4); if (s == 4) a_sel = 2'b11;
            for (int f = 0; f < 8; f++) begin
                d_fld_en = 1; d_fld = f[2:0]; step();
            end
            d_fld_en = 0; d_sel = s[1:0]; d_be = 2'b11; step();
        end
        idle();
    endtask

    task automatic pulse(input bit dh, input bit af, input bit ex);
        idle(); x_dehl = dh; x_af = af; x_exx = ex; step(); idle();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin cur[i] = '0; shd[i] = '0; end
        sp_m = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Fill every storage location before comparing
        awrite(2'd0, 0, 16'h1a2b); awrite(2'd1, 0, 16'h3c4d);
        awrite(2'd2, 0, 16'h5e6f); awrite(2'd3, 0, 16'h7081);
        awrite(2'd3, 1, 16'hfffe);
        pulse(0, 1, 1);
        awrite(2'd0, 0, 16'h9192); awrite(2'd1, 0, 16'ha3a4);
        awrite(2'd2, 0, 16'hb5b6); awrite(2'd3, 0, 16'hc7c8);
        pulse(0, 1, 1);
        cmp_on = 1;

        ctx = "R1 reset view"; sweep_reads();
        // R2: address-port pair and stack pointer writes
        ctx = "R2"; awrite(2'd2, 0, 16'h2468); awrite(2'd3, 1, 16'h1357); sweep_reads();
        // R3: byte-enable writes on the data port
        ctx = "R3";
        idle(); d_sel = 2'd1; d_be = 2'b10; d_we = 1; d_wdata = 16'hdead; step();
        idle(); d_sel = 2'd0; d_be = 2'b01; d_we = 1; d_wdata = 16'hbeef; step();
        idle(); d_sel = 2'd2; d_be = 2'b00; d_we = 1; d_wdata = 16'h0000; step();
        sweep_reads();
        // R4 / R5: field writes, including accumulator and flags
        ctx = "R5";
        idle(); d_fld_en = 1; d_fld = 3'b110; d_we = 1; d_wdata = 16'hd700; step();
        idle(); d_fld_en = 1; d_fld = 3'b111; d_we = 1; d_wdata = 16'h0042; step();
        ctx = "R4";
        idle(); d_fld_en = 1; d_fld = 3'b101; d_sel = 2'd0; d_be = 2'b10; d_we = 1; d_wdata = 16'h1199; step();
        sweep_reads();
        // R6: DE/HL swap
        ctx = "R6"; pulse(1, 0, 0); sweep_reads(); pulse(1, 0, 0); sweep_reads();
        // R7: accumulator/flags toggle
        ctx = "R7"; pulse(0, 1, 0); sweep_reads();
        // R8: bank switch with per-bank swap, then both together
        ctx = "R8"; pulse(1, 0, 0); pulse(0, 0, 1); sweep_reads();
        pulse(1, 0, 1); sweep_reads(); pulse(0, 0, 1); sweep_reads();
        // R10: write with exchange in the same cycle, and both ports on one byte
        ctx = "R10";
        idle(); a_sel = 2'd1; a_we = 1; a_wdata = 16'h4455; x_dehl = 1; x_exx = 1; step();
        idle(); a_sel = 2'd2; a_we = 1; a_wdata = 16'h6677;
        d_sel = 2'd2; d_be = 2'b01; d_we = 1; d_wdata = 16'h88ee; step();
        sweep_reads();
        // R11: reset mid-run keeps contents, clears pointers
        ctx = "R11";
        idle(); rst_n = 0; model_reset(); step(); step(); rst_n = 1; step();
        sweep_reads();

        ctx = "RND";
        for (int k = 0; k < 4000; k++) begin
            a_sel = 2'($urandom); a_use_sp = ($urandom % 3) == 0;
            a_we = ($urandom % 4) == 0; a_wdata = 16'($urandom);
            d_sel = 2'($urandom); d_be = 2'($urandom);
            d_fld_en = ($urandom % 2) == 0; d_fld = 3'($urandom);
            d_we = ($urandom % 3) == 0; d_wdata = 16'($urandom);
            x_dehl = ($urandom % 6) == 0; x_af = ($urandom % 7) == 0;
            x_exx = ($urandom % 6) == 0;
            if (k % 997 == 500) begin
                idle(); rst_n = 0; model_reset(); step(); rst_n = 1;
            end
            step();
        end
        idle(); step();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule